// File: doc/BRIEF.md
# Asynchronous Serial Frame Transmitter

This block turns parallel characters into asynchronous serial frames on a single line. A character enters a one-entry holding stage through a valid/ready write port. When the frame engine is idle it takes the character into its shift stage and sends a frame. The frame is a low start bit, then 5 to 8 data bits with the least significant bit first, then an optional parity bit, then a high stop period. All bit timing is counted in pulses of a single-cycle enable that runs at sixteen times the baud rate, so one bit lasts 16 enable pulses.

The frame format comes from plain control pins: character length, parity enable, parity sense and a long-stop select. These pins are captured when a character enters the shift stage. A break pin forces the line low without stopping the frame engine. Two status pins report an empty holding stage and a fully drained transmitter. Back-pressure rule: `wr_ready` is high exactly when the holding stage is empty. A character is accepted on a rising clock edge where `wr_valid` and `wr_ready` are both high. While `wr_ready` is low, the port ignores `wr_valid` and `wr_data` and the held character is kept.

Top module: `uart_tx_frame`

## Requirements
- R1: After reset `txd` is high, and `thr_empty`, `tx_empty` and `wr_ready` are all high.
- R2: `wr_ready` equals `thr_empty`. A write is taken only when `wr_valid` and `wr_ready` are both high. Data offered while the holding stage is full is dropped, and the held character is sent unchanged.
- R3: While the engine is idle, a held character moves into the shift stage on the next clock edge. `thr_empty` is high again from that edge.
- R4: A frame starts with a low start bit of 16 ticks. The data bits follow with the least significant bit first, each lasting 16 ticks.
- R5: `char_len` encodes the data length: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Data bits above the selected length are not sent.
- R6: With `par_en` high, one parity bit of 16 ticks follows the data. `par_odd` low gives even parity over the sent data bits, and high gives odd parity. With `par_en` low, no parity bit is sent.
- R7: The stop period is high. It lasts 16 ticks with `stop_long` low, 24 ticks with `stop_long` high and 5-bit characters, and 32 ticks with `stop_long` high and 6 to 8 bit characters.
- R8: `tx_empty` is high only when the holding stage is empty and the last stop tick has passed. A pending character starts its frame one clock after the previous stop period ends.
- R9: While `brk` is high, `txd` is low. Frame timing and status are unchanged by `brk`.
- R10: The format pins are captured when a character enters the shift stage. Changing them during a frame does not alter that frame.
- R11: Bit timing advances only on cycles where `tick16` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | Enable pulse at 16 times the baud rate |
| wr_valid | input | 1 | Character offered |
| wr_ready | output | 1 | Holding stage can accept a character |
| wr_data | input | 8 | Character to send, LSB first on the line |
| char_len | input | 2 | Data length code, 0..3 for 5..8 bits |
| par_en | input | 1 | Parity bit enable |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| stop_long | input | 1 | Selects 1.5 or 2 stop bits instead of 1 |
| brk | input | 1 | Force the line low |
| txd | output | 1 | Serial output, idles high |
| thr_empty | output | 1 | Holding stage is empty |
| tx_empty | output | 1 | Holding and shift stages are both empty |

## Verification
Back-pressure is the hardest case to reach from the ports. It needs a second character to be accepted in the short window after the first one leaves the holding stage, and a third character to be offered while the holding stage is full again. The bench runs a capture task and a stimulus thread in parallel under one fork. The stimulus writes the second character and then offers a third while the first frame is still in its start bit. The capture task decodes both frames and checks the one-clock gap between them. A similar parallel thread changes the format pins in the middle of a frame, to show that they are captured at load.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  localparam int LEN_W = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } tx_state_e;

  typedef struct packed {
    logic [LEN_W-1:0] len;
    logic             par_en;
    logic             par_odd;
    logic             stop_long;
  } tx_cfg_t;

endpackage

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  input  logic         take,
  output logic         full,
  output logic [W-1:0] out_data
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full     <= 1'b0;
      out_data <= '0;
    end else if (in_valid && !full) begin
      full     <= 1'b1;
      out_data <= in_data;
    end else if (take) begin
      full <= 1'b0;
    end
  end

  assign in_ready = !full;

endmodule

// File: rtl/uart_tx_seq.sv
module uart_tx_seq
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              avail,
  input  logic [DATA_W-1:0] ld_data,
  input  tx_cfg_t           cfg,
  output logic              take,
  output logic              line,
  output logic              busy
);

  localparam int CNT_W    = $clog2(2 * OVS);
  localparam int IDX_W    = $clog2(DATA_W);
  localparam int MIN_BITS = DATA_W - 3;

  localparam logic [CNT_W-1:0] BIT_LAST  = CNT_W'(OVS - 1);
  localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(OVS + OVS / 2 - 1);
  localparam logic [CNT_W-1:0] TWO_LAST  = CNT_W'(2 * OVS - 1);

  tx_state_e         state;
  tx_cfg_t           cfg_q;
  logic [DATA_W-1:0] shreg;
  logic [CNT_W-1:0]  tcnt;
  logic [IDX_W-1:0]  bidx;
  logic              par_q;
  logic [IDX_W-1:0]  last_idx;
  logic [CNT_W-1:0]  span_last;

  function automatic logic calc_par(input logic [DATA_W-1:0] d,
                                    input logic [LEN_W-1:0] len,
                                    input logic odd);
    logic acc;
    acc = odd;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < MIN_BITS + int'(len)) acc = acc ^ d[i];
    end
    return acc;
  endfunction

  assign last_idx = IDX_W'(MIN_BITS - 1) + IDX_W'(cfg_q.len);

  always_comb begin
    if (state != ST_STOP || !cfg_q.stop_long) span_last = BIT_LAST;
    else if (cfg_q.len == '0)                 span_last = HALF_LAST;
    else                                      span_last = TWO_LAST;
  end

  assign take = (state == ST_IDLE) && avail;
  assign busy = (state != ST_IDLE);

  always_comb begin
    unique case (state)
      ST_START: line = 1'b0;
      ST_DATA:  line = shreg[0];
      ST_PAR:   line = par_q;
      default:  line = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cfg_q <= '0;
      shreg <= '0;
      tcnt  <= '0;
      bidx  <= '0;
      par_q <= 1'b0;
    end else if (state == ST_IDLE) begin
      if (avail) begin
        state <= ST_START;
        cfg_q <= cfg;
        shreg <= ld_data;
        par_q <= calc_par(ld_data, cfg.len, cfg.par_odd);
        tcnt  <= '0;
        bidx  <= '0;
      end
    end else if (tick) begin
      if (tcnt != span_last) begin
        tcnt <= tcnt + 1'b1;
      end else begin
        tcnt <= '0;
        unique case (state)
          ST_START: state <= ST_DATA;
          ST_DATA: begin
            shreg <= shreg >> 1;
            if (bidx == last_idx) state <= cfg_q.par_en ? ST_PAR : ST_STOP;
            else                  bidx  <= bidx + 1'b1;
          end
          ST_PAR:  state <= ST_STOP;
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/uart_tx_frame.sv
module uart_tx_frame
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick16,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [LEN_W-1:0]  char_len,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              stop_long,
  input  logic              brk,
  output logic              txd,
  output logic              thr_empty,
  output logic              tx_empty
);

  logic              full;
  logic              take;
  logic              line;
  logic              busy;
  logic [DATA_W-1:0] held;
  tx_cfg_t           cfg;

  assign cfg = '{len: char_len, par_en: par_en, par_odd: par_odd, stop_long: stop_long};

  uart_tx_hold #(.W(DATA_W)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (wr_valid),
    .in_ready (wr_ready),
    .in_data  (wr_data),
    .take     (take),
    .full     (full),
    .out_data (held)
  );

  uart_tx_seq #(.DATA_W(DATA_W), .OVS(OVS)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick16),
    .avail   (full),
    .ld_data (held),
    .cfg     (cfg),
    .take    (take),
    .line    (line),
    .busy    (busy)
  );

  assign txd       = line & ~brk;
  assign thr_empty = !full;
  assign tx_empty  = !full && !busy;

endmodule

// File: rtl/uart_tx_frame_chk.sv
module uart_tx_frame_chk (
  input logic clk,
  input logic rst_n,
  input logic tick16,
  input logic wr_valid,
  input logic wr_ready,
  input logic brk,
  input logic txd,
  input logic thr_empty,
  input logic tx_empty
);

  a_r2_accept_fills: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=> !thr_empty);

  a_r8_empty_order: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |-> thr_empty);

  a_r8_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_empty && !brk) |-> txd);

  a_r9_break_low: assert property (@(posedge clk) disable iff (!rst_n)
    brk |-> !txd);

  a_r11_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick16 && !tx_empty && thr_empty) |=> ($stable(txd) || !$stable(brk)));

endmodule

bind uart_tx_frame uart_tx_frame_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick16    (tick16),
  .wr_valid  (wr_valid),
  .wr_ready  (wr_ready),
  .brk       (brk),
  .txd       (txd),
  .thr_empty (thr_empty),
  .tx_empty  (tx_empty)
);

// File: tb/sim_uart_tx_frame.sv
module sim_uart_tx_frame;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick16 = 1'b1;
  logic       wr_valid = 1'b0;
  logic       wr_ready;
  logic [7:0] wr_data = '0;
  logic [1:0] char_len = 2'd3;
  logic       par_en = 1'b0;
  logic       par_odd = 1'b0;
  logic       stop_long = 1'b0;
  logic       brk = 1'b0;
  logic       txd, thr_empty, tx_empty;

  int n_chk = 0;
  int n_fail = 0;
  int tick_div = 1;
  int tick_ph = 0;

  always #10 clk = ~clk;

  uart_tx_frame u0 (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_data(wr_data), .char_len(char_len),
    .par_en(par_en), .par_odd(par_odd), .stop_long(stop_long), .brk(brk),
    .txd(txd), .thr_empty(thr_empty), .tx_empty(tx_empty)
  );

  always @(negedge clk) begin
    tick_ph <= (tick_ph + 1 >= tick_div) ? 0 : tick_ph + 1;
    tick16  <= (tick_div == 1) || (tick_ph == 0);
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] d);
    @(negedge clk);
    while (!wr_ready) @(negedge clk);
    wr_valid = 1'b1;
    wr_data  = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  function automatic int frame_len(input int nb, input bit pe, input bit sl);
    int stop;
    stop = !sl ? 16 : (nb == 5 ? 24 : 32);
    return 16 * (1 + nb + (pe ? 1 : 0)) + stop;
  endfunction

  // Starts on the negedge before the first start-bit cycle; samples mid-bit.
  task automatic capture(input string req, input logic [7:0] d, input int nb, input bit pe,
                         input bit po, input bit sl, input bit bk, input bit end_empty);
    logic [15:0] got, exp;
    int len, bad_busy;
    bit p;
    len = frame_len(nb, pe, sl);
    p = po;
    for (int i = 0; i < nb; i++) p = p ^ d[i];
    got = '0; exp = '0;
    for (int k = 0; k < 16; k++) begin
      if (k == 0)                   exp[k] = 1'b0;
      else if (k <= nb)             exp[k] = d[k-1];
      else if (pe && k == nb + 1)   exp[k] = p;
      else                          exp[k] = 1'b1;
      if (bk) exp[k] = 1'b0;
      if (16 * k + 8 >= len) exp[k] = 1'b0;
    end
    bad_busy = 0;
    @(negedge clk);
    for (int c = 0; c < len; c++) begin
      if (c % 16 == 8) got[c / 16] = txd;
      if (tx_empty) bad_busy++;
      @(negedge clk);
    end
    chk(got == exp, {req, " bits"}, int'(got), int'(exp));
    chk(bad_busy == 0, {req, " R8 busy during frame"}, bad_busy, 0);
    chk(tx_empty == end_empty, {req, " R7 R8 end of stop"}, int'(tx_empty), int'(end_empty));
  endtask

  task automatic set_fmt(input int nb, input bit pe, input bit po, input bit sl);
    @(negedge clk);
    char_len = 2'(nb - 5); par_en = pe; par_odd = po; stop_long = sl;
  endtask

  task automatic t_reset;
    chk(txd == 1'b1, "R1 txd idle", int'(txd), 1);
    chk(thr_empty && tx_empty, "R1 empty flags", int'({thr_empty, tx_empty}), 3);
    chk(wr_ready == 1'b1, "R1 wr_ready", int'(wr_ready), 1);
  endtask

  task automatic t_basic;
    set_fmt(8, 0, 0, 0);
    send(8'hA5);
    capture("R4 8N1", 8'hA5, 8, 0, 0, 0, 0, 1);
    chk(txd == 1'b1, "R8 idle high after frame", int'(txd), 1);
  endtask

  task automatic t_len_parity;
    set_fmt(5, 1, 0, 0);
    send(8'hE7);
    capture("R5 R6 5-bit even", 8'hE7, 5, 1, 0, 0, 0, 1);
    set_fmt(7, 1, 1, 0);
    send(8'h35);
    capture("R6 7-bit odd", 8'h35, 7, 1, 1, 0, 0, 1);
    set_fmt(6, 1, 1, 0);
    send(8'h00);
    capture("R6 6-bit odd zero", 8'h00, 6, 1, 1, 0, 0, 1);
  endtask

  task automatic t_stops;
    set_fmt(5, 0, 0, 1);
    send(8'h13);
    capture("R7 1.5 stop", 8'h13, 5, 0, 0, 1, 0, 1);
    set_fmt(6, 1, 0, 1);
    send(8'h2C);
    capture("R7 2 stop", 8'h2C, 6, 1, 0, 1, 0, 1);
  endtask

  task automatic t_backpressure;
    set_fmt(8, 0, 0, 0);
    send(8'h3C);
    fork
      capture("R4 first of pair", 8'h3C, 8, 0, 0, 0, 0, 0);
      begin
        @(negedge clk);
        chk(thr_empty == 1'b1, "R3 holding freed at load", int'(thr_empty), 1);
        wr_valid = 1'b1; wr_data = 8'hC3;
        @(negedge clk);
        wr_data = 8'h5A;
        for (int i = 0; i < 3; i++) begin
          chk(wr_ready == 1'b0, "R2 ready low while full", int'(wr_ready), 0);
          @(negedge clk);
        end
        wr_valid = 1'b0;
      end
    join
    chk(txd == 1'b1, "R8 one idle clock between frames", int'(txd), 1);
    capture("R2 R8 held char sent", 8'hC3, 8, 0, 0, 0, 0, 1);
  endtask

  task automatic t_break;
    set_fmt(8, 1, 0, 0);
    @(negedge clk); brk = 1'b1;
    @(negedge clk);
    chk(txd == 1'b0, "R9 break while idle", int'(txd), 0);
    send(8'hFF);
    capture("R9 break frame", 8'hFF, 8, 1, 0, 0, 1, 1);
    brk = 1'b0;
    #1;
    chk(txd == 1'b1, "R9 line back high", int'(txd), 1);
  endtask

  task automatic t_cfg_hold;
    set_fmt(5, 1, 0, 1);
    send(8'h0B);
    fork
      capture("R10 format captured at load", 8'h0B, 5, 1, 0, 1, 0, 1);
      begin
        repeat (20) @(negedge clk);
        char_len = 2'd3; par_en = 1'b0; par_odd = 1'b1; stop_long = 1'b0;
      end
    join
  endtask

  task automatic t_slow_tick;
    int cyc;
    set_fmt(8, 0, 0, 0);
    @(negedge clk); tick_div = 2;
    send(8'h81);
    cyc = 0;
    @(negedge clk);
    while (!tx_empty && cyc < 1000) begin
      cyc++;
      @(negedge clk);
    end
    chk(cyc >= 318 && cyc <= 322, "R11 timing follows tick16", cyc, 320);
    tick_div = 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_len_parity();
    t_stops();
    t_backpressure();
    t_break();
    t_cfg_hold();
    t_slow_tick();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule